// File: doc/BRIEF.md
# Masked Vector Element Permute Unit

This block rearranges the elements of a 512-bit data vector under control of an index vector. Each destination lane reads a small index from the low bits of the matching lane of the index vector and copies the data element at that position. A source element may feed any number of destination lanes. Elements are 32 or 16 bits wide. The active vector length is 128, 256 or 512 bits. Every result bit above the active length is zero.

A per-lane write mask then decides what each lane receives. When masking is enabled, a lane with a clear mask bit either keeps the value from the old destination operand (merge) or becomes zero (zero mode). For 32-bit elements, a broadcast option places the lowest data element into every enabled lane, whatever its index. Combinations that are not allowed raise an illegal flag and pass the old destination through unchanged. The result and the flag are registered. They appear one cycle after a valid request is sampled.

Top module: `lane_shuffle_unit`

## Requirements
- R1: For each active lane j that is enabled, the result lane equals data element number k, where k is the masked index taken from lane j of idxVec. Several lanes may pick the same source element.
- R2: With 32-bit elements (elemIs16=0), the unit uses 3 index bits at vecLen=1 (256 bits, 8 lanes) and 4 index bits at vecLen=2 (512 bits, 16 lanes). All higher bits of each index element are ignored.
- R3: With 16-bit elements (elemIs16=1), the unit uses 3, 4 or 5 index bits at vecLen=0, 1 or 2 (128, 256 or 512 bits; 8, 16 or 32 lanes).
- R4: A lane is enabled when maskEnable=0, or when laneMask bit j is 1. Mask bits at or above the active lane count have no effect.
- R5: With maskEnable=1, a lane whose mask bit is 0 takes the matching lane of oldDest when zeroMasked=0, and takes zero when zeroMasked=1.
- R6: All result bits from the active vector length up to bit 511 are zero.
- R7: With bcastEn=1 and 32-bit elements, every enabled lane receives dataVec[31:0], whatever its index.
- R8: The request is illegal when any of these holds: 32-bit elements at vecLen=0, bcastEn=1 with 16-bit elements, or vecLen=3. An illegal request sets illegal=1 and makes the result equal to oldDest. A legal request clears illegal.
- R9: result, illegal and outValid update on the clock edge that samples inValid=1. outValid is high for exactly that one following cycle. Without inValid, result and illegal hold their values. A synchronous active-high rst clears outValid and illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Request strobe, sampled on the rising edge |
| idxVec | input | 512 | Per-lane index vector |
| dataVec | input | 512 | Source data vector |
| oldDest | input | 512 | Previous destination value, used for merge and for illegal requests |
| laneMask | input | 32 | Per-lane write mask; bit j controls lane j |
| elemIs16 | input | 1 | 1 = 16-bit elements, 0 = 32-bit elements |
| vecLen | input | 2 | 0 = 128, 1 = 256, 2 = 512 bits, 3 = reserved (illegal) |
| maskEnable | input | 1 | 1 = apply laneMask |
| zeroMasked | input | 1 | 1 = zero disabled lanes, 0 = merge from oldDest |
| bcastEn | input | 1 | Replicate dataVec[31:0] into enabled lanes |
| result | output | 512 | Registered permute result |
| illegal | output | 1 | Registered illegal-combination flag |
| outValid | output | 1 | High for one cycle when result and illegal are fresh |

## Verification
Every output comes from a single register stage. result, illegal and outValid are therefore due on the first rising edge after inValid is driven high. The bench drives each request on a falling edge and drops inValid on the next falling edge. It reads all three outputs at that point, half a cycle after the capturing edge. A further check one cycle later confirms that outValid has fallen while result and illegal hold. Expected values come from a behavioural shift-and-mask model in the bench, evaluated with the same operands.

// File: rtl/shuffle_pkg.sv
package shuffle_pkg;
  localparam int VEC_W    = 512;
  localparam int MIN_W    = 128;
  localparam int LIMIT_W  = 6;
  localparam int IDXM_W   = 5;

  typedef enum logic [1:0] {
    LEN128 = 2'd0,
    LEN256 = 2'd1,
    LEN512 = 2'd2,
    LENBAD = 2'd3
  } vlen_e;

  typedef struct packed {
    logic               capture;
    logic               legal;
    logic               use16;
    logic               bcast;
    logic               maskOn;
    logic               zeroMode;
    logic [IDXM_W-1:0]  idxMask;
    logic [LIMIT_W-1:0] laneLimit;
  } strobe_t;
endpackage

// File: rtl/shuffle_ctrl.sv
module shuffle_ctrl
  import shuffle_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic       elemIs16,
  input  logic [1:0] vecLen,
  input  logic       maskEnable,
  input  logic       zeroMasked,
  input  logic       bcastEn,
  output strobe_t    st,
  output logic       validQ
);
  logic badLen;
  logic bad32;
  logic bad16;
  logic [LIMIT_W-1:0] limit;

  always_comb begin
    badLen = (vecLen == LENBAD);
    bad32  = !elemIs16 && (vecLen == LEN128);
    bad16  = elemIs16 && bcastEn;
    // lanes = 128 << vecLen / element width
    if (elemIs16) limit = LIMIT_W'(8) << vecLen;
    else          limit = LIMIT_W'(4) << vecLen;

    st.capture   = inValid;
    st.legal     = !(badLen || bad32 || bad16);
    st.use16     = elemIs16;
    st.bcast     = bcastEn && !elemIs16;
    st.maskOn    = maskEnable;
    st.zeroMode  = zeroMasked;
    st.laneLimit = badLen ? '0 : limit;
    st.idxMask   = badLen ? '0 : IDXM_W'(limit - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (rst) validQ <= 1'b0;
    else     validQ <= inValid;
  end

  // R9: outValid follows the request by exactly one cycle
  a_r9_valid_latency: assert property (@(posedge clk) disable iff (rst)
    inValid |=> validQ);
  a_r9_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !validQ);
endmodule

// File: rtl/shuffle_elem_path.sv
module shuffle_elem_path
  import shuffle_pkg::*;
#(
  parameter int VW          = 512,
  parameter int ELEM_W      = 32,
  parameter bit ALLOW_BCAST = 1'b1
) (
  input  logic [VW-1:0]          idxVec,
  input  logic [VW-1:0]          dataVec,
  input  logic [VW-1:0]          oldDest,
  input  logic [VW/ELEM_W-1:0]   laneMask,
  input  strobe_t                st,
  output logic [VW-1:0]          laneOut
);
  localparam int LANES = VW / ELEM_W;
  localparam int IDX_W = $clog2(LANES);

  logic [ELEM_W-1:0] elems [LANES];

  for (genvar e = 0; e < LANES; e++) begin : g_split
    assign elems[e] = dataVec[e*ELEM_W +: ELEM_W];
  end

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [IDX_W-1:0]  pick;
    logic [ELEM_W-1:0] chosen;
    logic              active;
    logic              enable;

    assign pick   = idxVec[j*ELEM_W +: IDX_W] & st.idxMask[IDX_W-1:0];
    assign active = (j < int'(st.laneLimit));
    assign enable = !st.maskOn || laneMask[j];

    if (ALLOW_BCAST) begin : g_bc
      assign chosen = st.bcast ? elems[0] : elems[pick];
    end else begin : g_nobc
      assign chosen = elems[pick];
    end

    always_comb begin
      if (!active)          laneOut[j*ELEM_W +: ELEM_W] = '0;
      else if (enable)      laneOut[j*ELEM_W +: ELEM_W] = chosen;
      else if (st.zeroMode) laneOut[j*ELEM_W +: ELEM_W] = '0;
      else                  laneOut[j*ELEM_W +: ELEM_W] = oldDest[j*ELEM_W +: ELEM_W];
    end
  end
endmodule

// File: rtl/shuffle_datapath.sv
module shuffle_datapath
  import shuffle_pkg::*;
#(
  parameter int VW = VEC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [VW-1:0]     idxVec,
  input  logic [VW-1:0]     dataVec,
  input  logic [VW-1:0]     oldDest,
  input  logic [VW/16-1:0]  laneMask,
  input  strobe_t           st,
  output logic [VW-1:0]     resultQ,
  output logic              illegalQ
);
  localparam int LANES32 = VW / 32;
  localparam int LANES16 = VW / 16;

  logic [VW-1:0] wide32;
  logic [VW-1:0] wide16;
  logic [VW-1:0] nextResult;

  shuffle_elem_path #(.VW(VW), .ELEM_W(32), .ALLOW_BCAST(1'b1)) u_path32 (
    .idxVec  (idxVec),
    .dataVec (dataVec),
    .oldDest (oldDest),
    .laneMask(laneMask[LANES32-1:0]),
    .st      (st),
    .laneOut (wide32)
  );

  shuffle_elem_path #(.VW(VW), .ELEM_W(16), .ALLOW_BCAST(1'b0)) u_path16 (
    .idxVec  (idxVec),
    .dataVec (dataVec),
    .oldDest (oldDest),
    .laneMask(laneMask[LANES16-1:0]),
    .st      (st),
    .laneOut (wide16)
  );

  always_comb begin
    if (!st.legal)     nextResult = oldDest;
    else if (st.use16) nextResult = wide16;
    else               nextResult = wide32;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      illegalQ <= 1'b0;
    end else if (st.capture) begin
      illegalQ <= !st.legal;
    end
    if (st.capture) resultQ <= nextResult;
  end

  // R9: without a request the registered result stays put
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !st.capture |=> $stable(resultQ) && $stable(illegalQ));
endmodule

// File: rtl/lane_shuffle_unit.sv
module lane_shuffle_unit
  import shuffle_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  input  logic [511:0] idxVec,
  input  logic [511:0] dataVec,
  input  logic [511:0] oldDest,
  input  logic [31:0]  laneMask,
  input  logic         elemIs16,
  input  logic [1:0]   vecLen,
  input  logic         maskEnable,
  input  logic         zeroMasked,
  input  logic         bcastEn,
  output logic [511:0] result,
  output logic         illegal,
  output logic         outValid
);
  strobe_t st;

  shuffle_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .inValid   (inValid),
    .elemIs16  (elemIs16),
    .vecLen    (vecLen),
    .maskEnable(maskEnable),
    .zeroMasked(zeroMasked),
    .bcastEn   (bcastEn),
    .st        (st),
    .validQ    (outValid)
  );

  shuffle_datapath #(.VW(VEC_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .idxVec  (idxVec),
    .dataVec (dataVec),
    .oldDest (oldDest),
    .laneMask(laneMask),
    .st      (st),
    .resultQ (result),
    .illegalQ(illegal)
  );

  // R8: illegal request returns old destination and raises the flag
  a_r8_illegal_passthru: assert property (@(posedge clk) disable iff (rst)
    inValid && !st.legal |=> illegal && (result == $past(oldDest)));
  a_r8_bcast16_illegal: assert property (@(posedge clk) disable iff (rst)
    inValid && elemIs16 && bcastEn |=> illegal);
  // R6: a 128-bit request leaves the upper bits clear
  a_r6_upper_zero: assert property (@(posedge clk) disable iff (rst)
    inValid && elemIs16 && !bcastEn && (vecLen == 2'd0) |=> (result[511:128] == '0));
  // R5: zero mode with an empty mask clears the whole result
  a_r5_zero_all: assert property (@(posedge clk) disable iff (rst)
    inValid && st.legal && maskEnable && zeroMasked && (laneMask == '0) |=> (result == '0));
  // R7: broadcast puts the low data element into lane 1
  a_r7_bcast_lane1: assert property (@(posedge clk) disable iff (rst)
    inValid && !elemIs16 && bcastEn && !maskEnable && (vecLen == 2'd2)
    |=> (result[63:32] == $past(dataVec[31:0])));
  // R9: reset drops the output strobe
  a_r9_reset_clear: assert property (@(posedge clk)
    rst |=> !outValid && !illegal);
endmodule

// File: tb/lane_shuffle_unit_tb.sv
module lane_shuffle_unit_tb;
  localparam time CLK_PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rst;
  logic         inValid;
  logic [511:0] idxVec, dataVec, oldDest;
  logic [31:0]  laneMask;
  logic         elemIs16;
  logic [1:0]   vecLen;
  logic         maskEnable, zeroMasked, bcastEn;
  logic [511:0] result;
  logic         illegal, outValid;

  int  checkCount = 0;
  int  failCount  = 0;
  bit  finished   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_shuffle_unit u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .idxVec(idxVec), .dataVec(dataVec),
    .oldDest(oldDest), .laneMask(laneMask), .elemIs16(elemIs16), .vecLen(vecLen),
    .maskEnable(maskEnable), .zeroMasked(zeroMasked), .bcastEn(bcastEn),
    .result(result), .illegal(illegal), .outValid(outValid)
  );

  function automatic logic [511:0] rand512();
    logic [511:0] v;
    for (int k = 0; k < 16; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic void refModel(output logic [511:0] res, output bit ill);
    int w;
    int lanes;
    int bits;
    ill = (vecLen == 2'd3) || (!elemIs16 && vecLen == 2'd0) || (elemIs16 && bcastEn);
    res = '0;
    if (ill) begin
      res = oldDest;
      return;
    end
    w     = elemIs16 ? 16 : 32;
    lanes = (128 << vecLen) / w;
    bits  = $clog2(lanes);
    for (int j = 0; j < lanes; j++) begin
      logic [511:0] t;
      logic [511:0] lane;
      int sel;
      t    = idxVec >> (j * w);
      sel  = int'(t[4:0]) & ((1 << bits) - 1);
      t    = dataVec >> (sel * w);
      lane = elemIs16 ? 512'(t[15:0]) : 512'(t[31:0]);
      if (bcastEn) lane = 512'(dataVec[31:0]);
      if (maskEnable && !laneMask[j]) begin
        t    = oldDest >> (j * w);
        lane = zeroMasked ? '0 : (elemIs16 ? 512'(t[15:0]) : 512'(t[31:0]));
      end
      res = res | (lane << (j * w));
    end
  endfunction

  task automatic check(input bit ok, input string tag, input logic [511:0] act, input logic [511:0] exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive one request, read outputs half a cycle after the capturing edge
  task automatic runOp(input string tag);
    logic [511:0] expRes;
    bit expIll;
    refModel(expRes, expIll);
    @(negedge clk) inValid = 1'b1;
    @(negedge clk) inValid = 1'b0;
    check(outValid == 1'b1, {tag, " R9 outValid"}, 512'(outValid), 512'(1));
    check(result == expRes, {tag, " result"}, result, expRes);
    check(illegal == expIll, {tag, " R8 illegal"}, 512'(illegal), 512'(expIll));
  endtask

  task automatic setOp(input bit is16, input logic [1:0] vl, input bit men, input bit zm, input bit bc);
    elemIs16 = is16; vecLen = vl; maskEnable = men; zeroMasked = zm; bcastEn = bc;
    idxVec = rand512(); dataVec = rand512(); oldDest = rand512(); laneMask = $urandom;
  endtask

  task automatic testReset();
    rst = 1'b1; inValid = 1'b0;
    setOp(0, 2'd2, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(outValid == 1'b0, "R9 reset outValid", 512'(outValid), 512'(0));
    check(illegal == 1'b0, "R9 reset illegal", 512'(illegal), 512'(0));
  endtask

  task automatic testDword();
    for (int n = 0; n < 6; n++) begin
      setOp(0, (n % 2) ? 2'd2 : 2'd1, 0, 0, 0);
      runOp("R1 R2 R6 dword permute");
    end
    // all lanes point at element 3, high index bits set and ignored
    setOp(0, 2'd2, 0, 0, 0);
    for (int j = 0; j < 16; j++) idxVec[j*32 +: 32] = 32'hFFFF_FFF3;
    runOp("R1 R2 repeated source");
  endtask

  task automatic testWord();
    for (int n = 0; n < 6; n++) begin
      setOp(1, 2'(n % 3), 0, 0, 0);
      runOp("R3 R6 word permute");
    end
  endtask

  task automatic testMasks();
    for (int z = 0; z < 2; z++) begin
      setOp(0, 2'd2, 1, z[0], 0); laneMask = '1;
      runOp("R4 all-ones mask");
      setOp(1, 2'd1, 1, z[0], 0); laneMask = '0;
      runOp("R5 all-zeros mask");
      setOp(1, 2'd2, 1, z[0], 0);
      runOp("R5 random mask");
      // lanes 0..7 active; upper mask bits differ but must not matter
      setOp(1, 2'd0, 1, z[0], 0); laneMask = 32'hFFFF_FF5A;
      runOp("R4 upper mask ones");
      laneMask = 32'h0000_005A;
      runOp("R4 upper mask zeros");
    end
  endtask

  task automatic testBcast();
    setOp(0, 2'd2, 0, 0, 1);
    runOp("R7 broadcast 512");
    setOp(0, 2'd1, 1, 0, 1);
    runOp("R7 broadcast merge 256");
    setOp(0, 2'd2, 1, 1, 1);
    runOp("R7 broadcast zero 512");
  endtask

  task automatic testIllegal();
    setOp(0, 2'd0, 0, 0, 0);
    runOp("R8 dword at 128");
    setOp(1, 2'd2, 0, 0, 1);
    runOp("R8 word broadcast");
    setOp(1, 2'd3, 0, 0, 0);
    runOp("R8 reserved length");
    setOp(0, 2'd1, 0, 0, 0);
    runOp("R8 legal after illegal");
  endtask

  task automatic testHold();
    logic [511:0] keep;
    logic keepIll;
    setOp(1, 2'd2, 0, 0, 0);
    runOp("R9 hold setup");
    keep = result; keepIll = illegal;
    setOp(0, 2'd3, 0, 0, 0);
    @(negedge clk);
    check(outValid == 1'b0, "R9 outValid one cycle", 512'(outValid), 512'(0));
    check(result == keep, "R9 result held", result, keep);
    check(illegal == keepIll, "R9 illegal held", 512'(illegal), 512'(keepIll));
  endtask

  initial begin
    testReset();
    testDword();
    testWord();
    testMasks();
    testBcast();
    testIllegal();
    testHold();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end
endmodule